// File: doc/BRIEF.md
# Trip-Count Aged Victim Selector

This block makes the replacement decisions for one set of an exclusive, victim-style last-level cache. A line enters this cache only when the upper cache evicts it. A line that hits here leaves at once to move back up, so the block keeps no recency. Each way instead holds a small age, and the age a line gets on entry depends on one flag the upper cache sends with it. The flag tells whether the line has already made at least one round trip between the two levels. Lines that have come back before get a high age and are kept. Lines on their first trip get a low age, and a dueling select picks which of two low ages is used.

For each accepted fill the block chooses the target way. An empty way is used first. When the set is full, the valid line with the smallest age is evicted. The chosen way and a flag telling whether a valid line was displaced are registered and appear on the outputs in the next cycle. A hit, or an invalidate, names a way and frees it. Tags, data and coherence state are held elsewhere.

Top module: `tc_victim_sel`

## Requirements
- R1: After reset every way is empty and `victim_valid` is 0.
- R2: When `fill_force_en` is 0 and `fill_trip` is 1, the filled line gets age 3.
- R3: When `fill_force_en` is 0 and `fill_trip` is 0, the filled line gets age 1 if `duel_sel` is 0 and age 0 if `duel_sel` is 1.
- R4: When `fill_force_en` is 1, the filled line gets age `fill_force_age`, whatever `fill_trip` and `duel_sel` are.
- R5: If any way is empty, the fill goes to the lowest-numbered empty way and `victim_valid` is 0.
- R6: If every way is valid, the fill replaces the valid way with the smallest age. On a tie the lowest-numbered of the tied ways is taken, and `victim_valid` is 1.
- R7: When a fill evicts a line of age m, every other valid way has m subtracted from its age. The order of the survivors is kept, and the new line keeps its insertion age.
- R8: `hit_req` with way index `hit_way` empties that way, so a later fill can reuse it.
- R9: When `hit_req` and `fill_req` are both high in the same cycle, the hit is applied and the fill is ignored. No line is inserted, `victim_valid` is 0 and `victim_way` keeps its value.
- R10: `victim_way` and `victim_valid` are registered and change in the cycle after the accepted fill. `victim_valid` is 0 in every cycle that does not follow an accepted fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | Insert one line into the set |
| fill_trip | input | 1 | 1 when the line has made at least one round trip |
| fill_force_en | input | 1 | Use `fill_force_age` as the insertion age |
| fill_force_age | input | 2 | Forced insertion age |
| duel_sel | input | 1 | Selects age 0 (1) or age 1 (0) for first-trip lines |
| hit_req | input | 1 | Free the way named by `hit_way` |
| hit_way | input | $clog2(WAYS) | Way to free |
| victim_way | output | $clog2(WAYS) | Way used by the last accepted fill |
| victim_valid | output | 1 | The last accepted fill displaced a valid line |

## Verification
The bound properties check on every cycle that a freed way is empty one cycle later and that the target of each fill becomes valid. They also check that the insertion age follows the trip flag and the duel select, that an eviction is reported only from a full set, and that `victim_valid` never rises without an accepted fill. Some behaviour can only be shown through the bench's scenarios, because it depends on comparing all ways at once: the choice of the smallest age and its tie-break, the lowering of survivor ages, and a forced age changing the eviction order later on. The bench runs these against its own model of the set, across a long pseudo-random stream of fills and hits.

// File: rtl/tc_victim_pkg.sv
package tc_victim_pkg;
    localparam int AGE_W = 2;
    typedef logic [AGE_W-1:0] age_t;

    localparam age_t AGE_REUSED    = 2'd3;
    localparam age_t AGE_FIRST     = 2'd1;
    localparam age_t AGE_FIRST_ALT = 2'd0;

    function automatic age_t insert_age(input logic trip, input logic duel,
                                        input logic force_en, input age_t force_age);
        if (force_en)  return force_age;
        if (trip)      return AGE_REUSED;
        if (duel)      return AGE_FIRST_ALT;
        return AGE_FIRST;
    endfunction
endpackage

// File: rtl/tc_victim_pick.sv
module tc_victim_pick
    import tc_victim_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]        vld_i,
    input  age_t [WAYS-1:0]        age_i,
    output logic [IDX_W-1:0]       tgt_o,
    output logic                   evict_o
);
    logic             empty_found;
    logic [IDX_W-1:0] empty_idx;
    logic [IDX_W-1:0] min_idx;
    age_t             min_age;

    always_comb begin
        empty_found = 1'b0;
        empty_idx   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                empty_found = 1'b1;
                empty_idx   = IDX_W'(i);
            end
        end
        min_idx = '0;
        min_age = age_i[0];
        for (int i = 1; i < WAYS; i++) begin
            if (age_i[i] < min_age) begin
                min_age = age_i[i];
                min_idx = IDX_W'(i);
            end
        end
        tgt_o   = empty_found ? empty_idx : min_idx;
        evict_o = !empty_found;
    end
endmodule

// File: rtl/tc_victim_rebase.sv
module tc_victim_rebase
    import tc_victim_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld_i,
    input  age_t [WAYS-1:0]  age_i,
    input  logic [IDX_W-1:0] tgt_i,
    input  logic             evict_i,
    input  age_t             ins_age_i,
    output logic [WAYS-1:0]  vld_o,
    output age_t [WAYS-1:0]  age_o
);
    age_t shift;
    assign shift = evict_i ? age_i[tgt_i] : '0;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic is_tgt;
        assign is_tgt   = (tgt_i == IDX_W'(g));
        assign vld_o[g] = vld_i[g] | is_tgt;
        assign age_o[g] = is_tgt ? ins_age_i
                        : (vld_i[g] ? age_i[g] - shift : age_i[g]);
    end
endmodule

// File: rtl/tc_victim_sel.sv
module tc_victim_sel
    import tc_victim_pkg::*;
#(
    parameter int WAYS  = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_req,
    input  logic             fill_trip,
    input  logic             fill_force_en,
    input  logic [AGE_W-1:0] fill_force_age,
    input  logic             duel_sel,
    input  logic             hit_req,
    input  logic [IDX_W-1:0] hit_way,
    output logic [IDX_W-1:0] victim_way,
    output logic             victim_valid
);
    typedef struct packed {
        logic [WAYS-1:0]  vld;
        age_t [WAYS-1:0]  age;
        logic [IDX_W-1:0] vway;
        logic             vvalid;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0] tgt;
    logic             evict;
    age_t             ins_age;
    logic [WAYS-1:0]  reb_vld;
    age_t [WAYS-1:0]  reb_age;

    assign ins_age = insert_age(fill_trip, duel_sel, fill_force_en, fill_force_age);

    tc_victim_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) pick_i (
        .vld_i  (s_q.vld),
        .age_i  (s_q.age),
        .tgt_o  (tgt),
        .evict_o(evict)
    );

    tc_victim_rebase #(.WAYS(WAYS), .IDX_W(IDX_W)) rebase_i (
        .vld_i    (s_q.vld),
        .age_i    (s_q.age),
        .tgt_i    (tgt),
        .evict_i  (evict),
        .ins_age_i(ins_age),
        .vld_o    (reb_vld),
        .age_o    (reb_age)
    );

    always_comb begin
        s_d        = s_q;
        s_d.vvalid = 1'b0;
        if (hit_req) begin
            s_d.vld[hit_way] = 1'b0;
        end else if (fill_req) begin
            s_d.vld    = reb_vld;
            s_d.age    = reb_age;
            s_d.vway   = tgt;
            s_d.vvalid = evict;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign victim_way   = s_q.vway;
    assign victim_valid = s_q.vvalid;
endmodule

// File: rtl/tc_victim_sel_chk.sv
module tc_victim_sel_chk
    import tc_victim_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_req,
    input logic             fill_trip,
    input logic             fill_force_en,
    input logic             duel_sel,
    input logic             hit_req,
    input logic [IDX_W-1:0] hit_way,
    input logic [IDX_W-1:0] victim_way,
    input logic             victim_valid,
    input logic [WAYS-1:0]  vld_q,
    input age_t [WAYS-1:0]  age_q
);
    p_reused_age_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !hit_req && fill_trip && !fill_force_en) |=> age_q[victim_way] == AGE_REUSED);

    p_alt_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !hit_req && !fill_trip && !fill_force_en && duel_sel) |=> age_q[victim_way] == AGE_FIRST_ALT);

    p_evict_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !hit_req) |=> (victim_valid == $past(&vld_q)));

    p_fill_occupies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !hit_req) |=> vld_q[victim_way]);

    p_hit_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_req |=> !vld_q[$past(hit_way)]);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && !hit_req) |=> !victim_valid);

    p_hold_on_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && hit_req) |=> $stable(victim_way));
endmodule

bind tc_victim_sel tc_victim_sel_chk #(.WAYS(WAYS), .IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_req     (fill_req),
    .fill_trip    (fill_trip),
    .fill_force_en(fill_force_en),
    .duel_sel     (duel_sel),
    .hit_req      (hit_req),
    .hit_way      (hit_way),
    .victim_way   (victim_way),
    .victim_valid (victim_valid),
    .vld_q        (s_q.vld),
    .age_q        (s_q.age)
);

// File: tb/tc_victim_sel_tb_top.sv
module tc_victim_sel_tb_top;
    localparam int WAYS  = 8;
    localparam int IDX_W = $clog2(WAYS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fill_req = 1'b0, fill_trip = 1'b0, fill_force_en = 1'b0, duel_sel = 1'b0;
    logic [1:0]       fill_force_age = 2'd0;
    logic             hit_req = 1'b0;
    logic [IDX_W-1:0] hit_way = '0;
    logic [IDX_W-1:0] victim_way;
    logic             victim_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int bvld [WAYS];
    int bage [WAYS];
    int last_way = 0;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    tc_victim_sel #(.WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_trip(fill_trip),
        .fill_force_en(fill_force_en), .fill_force_age(fill_force_age),
        .duel_sel(duel_sel), .hit_req(hit_req), .hit_way(hit_way),
        .victim_way(victim_way), .victim_valid(victim_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_age(bit trip, bit duel, bit fe, int fa);
        if (fe) return fa;
        if (trip) return 3;
        return duel ? 0 : 1;
    endfunction

    task automatic do_fill(input bit trip, input bit duel, input bit fe, input int fa, input string req);
        int t = -1;
        bit ev = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) if (bvld[i] == 0) t = i;
        if (t < 0) begin
            ev = 1'b1;
            t = 0;
            for (int i = 1; i < WAYS; i++) if (bage[i] < bage[t]) t = i;
            for (int i = 0; i < WAYS; i++) if (i != t) bage[i] -= bage[t];
        end
        bage[t] = model_age(trip, duel, fe, fa);
        bvld[t] = 1;
        last_way = t;
        @(negedge clk);
        fill_req = 1'b1; fill_trip = trip; duel_sel = duel;
        fill_force_en = fe; fill_force_age = 2'(fa);
        @(negedge clk);
        fill_req = 1'b0; fill_force_en = 1'b0;
        chk({req, " way"}, int'(victim_way), t);
        chk({req, " valid"}, int'(victim_valid), int'(ev));
    endtask

    task automatic do_hit(input int w);
        bvld[w] = 0;
        @(negedge clk);
        hit_req = 1'b1; hit_way = IDX_W'(w);
        @(negedge clk);
        hit_req = 1'b0;
        chk("R10 no pulse after hit", int'(victim_valid), 0);
    endtask

    task automatic t_reset;
        for (int i = 0; i < WAYS; i++) begin bvld[i] = 0; bage[i] = 0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset victim_valid", int'(victim_valid), 0);
        do_fill(1'b0, 1'b0, 1'b0, 0, "R1 first fill to way 0");
    endtask

    task automatic t_fill_empty;
        do_fill(1'b1, 1'b0, 1'b0, 0, "R5 R2 trip line");
        do_fill(1'b0, 1'b1, 1'b0, 0, "R5 R3 alt age");
        do_fill(1'b0, 1'b0, 1'b1, 2, "R5 R4 forced 2");
        do_fill(1'b1, 1'b1, 1'b1, 0, "R4 forced 0 over trip");
        do_fill(1'b0, 1'b0, 1'b0, 0, "R3 static age");
        do_fill(1'b1, 1'b0, 1'b0, 0, "R2 trip line");
        do_fill(1'b0, 1'b1, 1'b0, 0, "R5 last empty");
    endtask

    task automatic t_full;
        do_fill(1'b1, 1'b0, 1'b0, 0, "R6 evict age0 low way");
        do_fill(1'b1, 1'b0, 1'b0, 0, "R6 tie break");
        do_fill(1'b0, 1'b0, 1'b0, 0, "R7 rebased survivors");
        do_fill(1'b0, 1'b1, 1'b0, 0, "R7 order kept");
        do_fill(1'b0, 1'b0, 1'b1, 3, "R4 R6 forced 3");
        do_fill(1'b0, 1'b0, 1'b0, 0, "R7 after forced");
    endtask

    task automatic t_hit;
        do_hit(5);
        do_fill(1'b1, 1'b0, 1'b0, 0, "R8 refill freed way");
        do_hit(2);
        do_hit(6);
        do_fill(1'b0, 1'b0, 1'b0, 0, "R8 lowest freed way");
        do_fill(1'b0, 1'b0, 1'b0, 0, "R8 next freed way");
    endtask

    task automatic t_clash;
        int held = last_way;
        bvld[3] = 0;
        @(negedge clk);
        fill_req = 1'b1; fill_trip = 1'b1; hit_req = 1'b1; hit_way = IDX_W'(3);
        @(negedge clk);
        fill_req = 1'b0; hit_req = 1'b0;
        chk("R9 fill ignored valid", int'(victim_valid), 0);
        chk("R9 way held", int'(victim_way), held);
        do_fill(1'b0, 1'b0, 1'b0, 0, "R9 hit applied only");
        do_fill(1'b0, 1'b0, 1'b0, 0, "R9 set full again");
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R10 idle low", int'(victim_valid), 0);
    endtask

    task automatic t_stream;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] == 3'd0) do_hit(int'(lf[6:4]) % WAYS);
            else do_fill(lf[3], lf[7], lf[8] & lf[9], int'(lf[11:10]), "R6 R7 stream");
        end
    endtask

    initial begin
        t_reset;
        t_fill_empty;
        t_full;
        t_hit;
        t_clash;
        t_idle;
        t_stream;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule